// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block is the status and interrupt register of a descriptor-based DMA engine that serves a card host interface. The engine sends it one-cycle event pulses: a transmit descriptor has finished, a receive descriptor has finished, a fatal bus error has occurred (with a 3-bit error type), a fetched descriptor is not owned by the engine, or one of seven card error conditions has occurred. The block latches each event into a status bit. Software clears a status bit by writing 1 to its position.

Two sticky summary bits collect the events that are enabled in a 4-bit mask. The normal summary covers the two completion events. The abnormal summary covers the bus error and the unowned descriptor. An interrupt output is the OR of the two summaries. Bits 16:13 of the read word show the engine's current state code. These bits are read-only and are wired straight through. The block also drives two controls. A bus-disable output is high while the fatal bus error bit is set. An abort request is raised when a response error arrives while the card error summary is already set.

The register port is a plain synchronous write port. A write with `wr_en` high takes effect at the next rising clock edge. The read word `rd_data` always shows the current register contents.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every field reads zero: `rd_data` is 0, and `irq`, `bus_disable` and `abort_req` are low.
- R2: Each event pulse sets its status bit at the next clock edge. Transmit done sets bit 0, receive done sets bit 1 and a fatal bus error sets bit 2. The set bit stays until software clears it.
- R3: A write with a 1 at bit 0, 1, 2, 4, 5, 8 or 9 clears that bit at the next clock edge. A write with a 0 at any of these bits leaves the bit unchanged.
- R4: Bits 3, 7:6 and 31:17 always read 0. A write to these bits, or to bits 16:10, has no effect on any field.
- R5: The normal summary at bit 8 is set when bit 0 is set and mask bit 0 is 1, or when bit 1 is set and mask bit 1 is 1. Once set, it stays set until software writes 1 to bit 8.
- R6: The abnormal summary at bit 9 is set when bit 2 is set and mask bit 2 is 1, or when bit 4 is set and mask bit 3 is 1. Once set, it stays set until software writes 1 to bit 9.
- R7: The error type at bits 12:10 is loaded from the error code input when a bus error arrives while bit 2 is clear or is being cleared in the same cycle. A later bus error keeps the first code. The field reads 0 whenever bit 2 is clear. Code 001 means a host abort during transmission and 010 means a host abort during reception.
- R8: `bus_disable` is high exactly while bit 2 is set.
- R9: Bit 4 is set at the next clock edge when a descriptor check strobe arrives with the ownership flag at 0. A strobe with the ownership flag at 1 does not set bit 4.
- R10: Bit 5 is set at the next clock edge when any bit of `card_err` is high. The bits of `card_err` are: 0 end bit error, 1 response timeout, 2 response CRC error, 3 start bit error, 4 data read timeout, 5 data receive CRC error, 6 response error.
- R11: `abort_req` equals `card_err[6]` AND the current bit 5, combinationally. So a response error does not abort while bit 5 is clear.
- R12: Bits 16:13 always equal `eng_state`. The state codes are: 0 idle, 1 suspend, 2 descriptor read, 3 descriptor check, 4 read request wait, 5 write request wait, 6 read, 7 write, 8 descriptor close.
- R13: When a hardware set condition and a software write-1 clear hit the same bit in the same cycle, the bit is 1 after the edge.
- R14: `irq` equals bit 8 OR bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; a 1 at a status bit clears that bit |
| rd_data | output | 32 | Current register contents |
| ev_tx_done | input | 1 | Transmit descriptor done pulse |
| ev_rx_done | input | 1 | Receive descriptor done pulse |
| ev_bus_err | input | 1 | Fatal bus error pulse |
| ev_bus_err_code | input | 3 | Error type that comes with the bus error |
| desc_chk | input | 1 | Descriptor check strobe |
| desc_own | input | 1 | Ownership flag of the checked descriptor |
| card_err | input | 7 | Card error pulses (bit meanings in R10) |
| irq_mask | input | 4 | Summary enables: 0 transmit, 1 receive, 2 bus error, 3 unowned descriptor |
| eng_state | input | 4 | Engine state code |
| irq | output | 1 | Interrupt request |
| bus_disable | output | 1 | Stops all DMA bus access |
| abort_req | output | 1 | Transfer abort request |

## Verification
Two things can hit the same bit in one cycle: a hardware set, and a software write-1 clear of that bit or of a summary bit that depends on it. The bench provokes this by driving event pulses, descriptor strobes and card errors from a pseudo-random stream. In the same cycles it issues writes with random data. It also sweeps the mask through all 16 values. A cycle model in the bench, built from the set-wins and stickiness rules, judges every edge. It compares the result against each field and each output, including the error type when a new bus error meets a clear of bit 2.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W  = 32;
  localparam int NUM_EV = 5;
  localparam int POS_NIS  = 8;
  localparam int POS_AIS  = 9;
  localparam int POS_CODE = 10;

  // event slot -> bit position in the read word
  function automatic int ev_pos(input int slot);
    case (slot)
      0: ev_pos = 0;
      1: ev_pos = 1;
      2: ev_pos = 2;
      3: ev_pos = 4;
      default: ev_pos = 5;
    endcase
  endfunction

  // sticky bit with set priority over write-1 clear
  function automatic logic w1c_next(input logic set, input logic q, input logic clr);
    w1c_next = set | (q & ~clr);
  endfunction
endpackage

// File: rtl/dis_w1c_bit.sv
module dis_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q,
  output logic q_next
);
  import dma_irq_pkg::*;

  assign q_next = w1c_next(set, q, clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end
endmodule

// File: rtl/dis_summary.sv
module dis_summary #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_next,
  input  logic [N-1:0] enable,
  input  logic         clr,
  output logic         q,
  output logic         hit
);
  import dma_irq_pkg::*;

  assign hit = |(src_next & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= w1c_next(hit, q, clr);
  end
endmodule

// File: rtl/dis_err_code.sv
module dis_err_code #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_ev,
  input  logic [W-1:0] err_code,
  input  logic         fbe_q,
  input  logic         fbe_clr,
  input  logic         fbe_next,
  output logic [W-1:0] code_q,
  output logic         code_load
);
  logic [W-1:0] code_d;

  assign code_load = err_ev & (~fbe_q | fbe_clr);

  always_comb begin
    if (code_load)     code_d = err_code;
    else if (fbe_next) code_d = code_q;
    else               code_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int CODE_W   = 3,
  parameter int STATE_W  = 4,
  parameter int N_CARD   = 7,
  parameter int RESP_IDX = 6,
  parameter int MASK_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [dma_irq_pkg::REG_W-1:0]  wr_data,
  output logic [dma_irq_pkg::REG_W-1:0]  rd_data,
  input  logic                           ev_tx_done,
  input  logic                           ev_rx_done,
  input  logic                           ev_bus_err,
  input  logic [CODE_W-1:0]              ev_bus_err_code,
  input  logic                           desc_chk,
  input  logic                           desc_own,
  input  logic [N_CARD-1:0]              card_err,
  input  logic [MASK_W-1:0]              irq_mask,
  input  logic [STATE_W-1:0]             eng_state,
  output logic                           irq,
  output logic                           bus_disable,
  output logic                           abort_req
);
  import dma_irq_pkg::*;

  localparam int POS_STATE = POS_CODE + CODE_W;

  logic [REG_W-1:0]  clr_vec;
  logic [NUM_EV-1:0] ev_set, ev_clr, ev_q, ev_next;
  logic              du_set, ces_set;
  logic              nis_q, ais_q, nis_hit, ais_hit;
  logic [CODE_W-1:0] code_q;
  logic              code_load;

  assign clr_vec = wr_en ? wr_data : '0;
  assign du_set  = desc_chk & ~desc_own;
  assign ces_set = |card_err;
  assign ev_set  = {ces_set, du_set, ev_bus_err, ev_rx_done, ev_tx_done};

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    assign ev_clr[i] = clr_vec[ev_pos(i)];
    dis_w1c_bit u_bit (
      .clk(clk), .rst_n(rst_n), .set(ev_set[i]), .clr(ev_clr[i]),
      .q(ev_q[i]), .q_next(ev_next[i])
    );
  end

  dis_summary #(.N(2)) u_nis (
    .clk(clk), .rst_n(rst_n), .src_next(ev_next[1:0]), .enable(irq_mask[1:0]),
    .clr(clr_vec[POS_NIS]), .q(nis_q), .hit(nis_hit)
  );

  dis_summary #(.N(2)) u_ais (
    .clk(clk), .rst_n(rst_n), .src_next(ev_next[3:2]), .enable(irq_mask[3:2]),
    .clr(clr_vec[POS_AIS]), .q(ais_q), .hit(ais_hit)
  );

  dis_err_code #(.W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .err_ev(ev_bus_err), .err_code(ev_bus_err_code),
    .fbe_q(ev_q[2]), .fbe_clr(ev_clr[2]), .fbe_next(ev_next[2]),
    .code_q(code_q), .code_load(code_load)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_EV; i++) rd_data[ev_pos(i)] = ev_q[i];
    rd_data[POS_NIS] = nis_q;
    rd_data[POS_AIS] = ais_q;
    rd_data[POS_CODE +: CODE_W]   = code_q;
    rd_data[POS_STATE +: STATE_W] = eng_state;
  end

  assign irq         = nis_q | ais_q;
  assign bus_disable = ev_q[2];
  assign abort_req   = card_err[RESP_IDX] & ev_q[4];
endmodule

module dis_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        ev_tx_done,
  input logic        ev_rx_done,
  input logic        ev_bus_err,
  input logic        desc_chk,
  input logic        desc_own,
  input logic [6:0]  card_err,
  input logic [3:0]  eng_state,
  input logic        irq,
  input logic        bus_disable,
  input logic        abort_req
);
  p_tx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> rd_data[0]);
  p_rx_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && wr_en && wr_data[1]) |=> rd_data[1]);
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:17] == 15'd0) && (rd_data[7:6] == 2'd0) && !rd_data[3]);
  p_nis_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[8] && !(wr_en && wr_data[8])) |=> rd_data[8]);
  p_ais_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[9] && !(wr_en && wr_data[9])) |=> rd_data[9]);
  p_code_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[2] |-> (rd_data[12:10] == 3'd0));
  p_busdis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_disable == rd_data[2]);
  p_du_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_chk && !desc_own) |=> rd_data[4]);
  p_ces_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (card_err != 7'd0) |=> rd_data[5]);
  p_abort_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (rd_data[5] && card_err[6]));
  p_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[16:13] == eng_state);
  p_irq_r14: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[8] | rd_data[9]));
endmodule

bind dma_irq_status dis_checker u_chk (.*);

// File: tb/dma_irq_status_bench.sv
module dma_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ev_tx_done = 0, ev_rx_done = 0, ev_bus_err = 0;
  logic [2:0]  ev_bus_err_code = '0;
  logic        desc_chk = 0, desc_own = 0;
  logic [6:0]  card_err = '0;
  logic [3:0]  irq_mask = '0;
  logic [3:0]  eng_state = '0;
  logic        irq, bus_disable, abort_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_irq_status u_dma_irq_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_bus_err(ev_bus_err),
    .ev_bus_err_code(ev_bus_err_code), .desc_chk(desc_chk), .desc_own(desc_own),
    .card_err(card_err), .irq_mask(irq_mask), .eng_state(eng_state),
    .irq(irq), .bus_disable(bus_disable), .abort_req(abort_req)
  );

  // bench model of register contents
  logic m_ti, m_ri, m_fbe, m_du, m_ces, m_nis, m_ais;
  logic [2:0] m_code;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {15'd0, eng_state, m_code, m_ais, m_nis, 2'd0, m_ces, m_du, 1'b0, m_fbe, m_ri, m_ti};
  endfunction

  task automatic check_all();
    logic [31:0] e;
    e = exp_word();
    chk("R2/R3/R13 done bits", {30'd0, rd_data[1:0]}, {30'd0, e[1:0]});
    chk("R8 fatal bit and bus_disable", {30'd0, rd_data[2], bus_disable}, {30'd0, m_fbe, m_fbe});
    chk("R9 desc unavailable", {31'd0, rd_data[4]}, {31'd0, m_du});
    chk("R10 card error summary", {31'd0, rd_data[5]}, {31'd0, m_ces});
    chk("R5/R6 summaries", {30'd0, rd_data[9:8]}, {30'd0, m_ais, m_nis});
    chk("R7 error type", {29'd0, rd_data[12:10]}, {29'd0, m_code});
    chk("R4/R12 reserved and state", rd_data & 32'hFFFF_E0C8, e & 32'hFFFF_E0C8);
    chk("R14 irq", {31'd0, irq}, {31'd0, m_nis | m_ais});
  endtask

  // advance model by one edge using current inputs
  task automatic model_step();
    logic [31:0] c;
    logic n_ti, n_ri, n_fbe, n_du, n_ces;
    c = wr_en ? wr_data : 32'd0;
    n_ti  = ev_tx_done | (m_ti & !c[0]);
    n_ri  = ev_rx_done | (m_ri & !c[1]);
    n_fbe = ev_bus_err | (m_fbe & !c[2]);
    n_du  = (desc_chk & !desc_own) | (m_du & !c[4]);
    n_ces = (card_err != 0) | (m_ces & !c[5]);
    if (ev_bus_err && (!m_fbe || c[2])) m_code = ev_bus_err_code;
    else if (!n_fbe) m_code = 3'd0;
    m_nis = (irq_mask[0] & n_ti) | (irq_mask[1] & n_ri) | (m_nis & !c[8]);
    m_ais = (irq_mask[2] & n_fbe) | (irq_mask[3] & n_du) | (m_ais & !c[9]);
    m_ti = n_ti; m_ri = n_ri; m_fbe = n_fbe; m_du = n_du; m_ces = n_ces;
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; ev_tx_done = 0; ev_rx_done = 0; ev_bus_err = 0;
    ev_bus_err_code = '0; desc_chk = 0; desc_own = 0; card_err = '0;
  endtask

  initial begin
    logic [31:0] r;
    {m_ti, m_ri, m_fbe, m_du, m_ces, m_nis, m_ais} = '0;
    m_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 32'd0);
    chk("R1 reset outputs", {29'd0, irq, bus_disable, abort_req}, 32'd0);

    // R12: state mirror sweep
    for (int s = 0; s <= 8; s++) begin
      eng_state = s[3:0];
      #1 chk("R12 state field", {28'd0, rd_data[16:13]}, s);
    end

    // R4: writes to reserved and read-only bits are ignored
    @(negedge clk);
    wr_en = 1; wr_data = 32'hFFFF_FCC8;
    model_step();
    @(negedge clk);
    idle_inputs();
    chk("R4 reserved write ignored", rd_data, exp_word());

    // R11: response error with card error summary clear does not abort
    card_err = 7'h40;
    #1 chk("R11 no abort while summary clear", {31'd0, abort_req}, 32'd0);
    model_step();
    @(negedge clk);
    #1 chk("R11 abort while summary set", {31'd0, abort_req}, 32'd1);
    model_step();
    @(negedge clk);
    idle_inputs();
    // R7: first code kept, later error does not overwrite
    ev_bus_err = 1; ev_bus_err_code = 3'b001;
    model_step();
    @(negedge clk);
    ev_bus_err_code = 3'b010;
    model_step();
    @(negedge clk);
    idle_inputs();
    chk("R7 first code kept", {29'd0, rd_data[12:10]}, 32'd1);
    wr_en = 1; wr_data = 32'h0000_0024;
    model_step();
    @(negedge clk);
    idle_inputs();
    chk("R7 code cleared with fatal bit", {29'd0, rd_data[12:10]}, 32'd0);
    chk("R3 clear fatal and card bits", {30'd0, rd_data[5], rd_data[2]}, 32'd0);
    // R9: owned descriptor does not set the bit
    desc_chk = 1; desc_own = 1;
    model_step();
    @(negedge clk);
    idle_inputs();
    chk("R9 owned descriptor ignored", {31'd0, rd_data[4]}, 32'd0);

    // random sweep with all mask values
    r = 32'h1234_5678;
    for (int it = 0; it < 8192; it++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      irq_mask  = it[12:9];
      eng_state = 4'(r[25:22] % 9);
      ev_tx_done = r[0] & r[1];
      ev_rx_done = r[2] & r[3];
      ev_bus_err = r[4] & r[5] & r[6];
      ev_bus_err_code = r[9:7];
      desc_chk = r[10] & r[11];
      desc_own = r[12];
      card_err = (r[26] & r[27] & r[28]) ? r[19:13] : 7'd0;
      wr_en = r[20] & r[21];
      wr_data = {r[3:0], r[31:4]};
      #1 chk("R11 abort", {31'd0, abort_req}, {31'd0, card_err[6] & m_ces});
      model_step();
      @(negedge clk);
      check_all();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule